// File: doc/BRIEF.md
# DSP Address Generation Unit

This block forms the data address for each load or store of a signal-processing core. A three-bit mode input picks one of six ways to build the address. Three modes combine registers: base plus a signed immediate, base plus an index register, and base plus a shifted index for row-major tables. Three modes walk a pointer: a ring buffer that wraps by itself, a pointer whose low bits are mirrored for FFT butterflies, and a plain strided walk over vector data.

The address leaves the block in the same cycle as its operands. In the three pointer-walking modes the block also works out the pointer for the next access. When the update strobe is high, it registers that pointer and flags it valid for one cycle, so the core can write it back to its register file. Register storage, memory access and instruction decode live outside the block.

Top module: `dsp_agu`

## Requirements
- R1: While reset is asserted (rst_n low), ptr_next is 0 and ptr_valid is 0.
- R2: In mode 0 (displacement), eff_addr equals base plus offset, modulo 2^AW. The offset is two's complement, so 16'hFFFC subtracts 4.
- R3: In mode 1 (indexed), eff_addr equals base plus index, modulo 2^AW.
- R4: In mode 2 (scaled), eff_addr equals base plus index shifted left by scale_sh, modulo 2^AW. A shift of 3 gives a row size of 8.
- R5: In mode 3 (ring buffer), eff_addr equals base. The next pointer is base plus step, less buf_len when that sum reaches or passes buf_start plus buf_len.
- R6: In mode 4 (bit-reversed), eff_addr is base with its low rev_bits bits put in mirror order and its upper bits unchanged. Values of rev_bits above AW mirror all AW bits. The next pointer is base plus step, modulo 2^AW.
- R7: In mode 4, a rev_bits of 0 passes base through to eff_addr unchanged.
- R8: In mode 5 (strided), eff_addr equals base and the next pointer is base plus step, modulo 2^AW.
- R9: After a rising clock edge with upd_en high and mode 3, 4 or 5, ptr_valid is 1 and ptr_next holds the next pointer. After an edge with upd_en low, ptr_valid is 0 and ptr_next keeps its value.
- R10: Modes 6 and 7 are reserved. They give eff_addr equal to base, and even with upd_en high they leave ptr_valid at 0 and ptr_next unchanged.
- R11: eff_addr is combinational: it follows a change of base within the same clock cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Address mode, 0 to 7 |
| base | input | AW (16) | Base register, or the current pointer in modes 3 to 5 |
| index | input | AW (16) | Index register for modes 1 and 2 |
| offset | input | AW (16) | Signed immediate displacement for mode 0 |
| scale_sh | input | SHW (2) | Left shift applied to index in mode 2 |
| buf_start | input | AW (16) | First address of the ring buffer |
| buf_len | input | AW (16) | Ring buffer length in address units |
| step | input | AW (16) | Pointer increment for modes 3 to 5 |
| rev_bits | input | NW (5) | Number of low bits to mirror in mode 4 |
| upd_en | input | 1 | Register the next pointer this cycle |
| eff_addr | output | AW (16) | Effective address, combinational |
| ptr_next | output | AW (16) | Registered next pointer |
| ptr_valid | output | 1 | ptr_next was loaded on the last edge |

## Verification
The ring-buffer property assumes a well-formed ring: a pointer that already lies inside [buf_start, buf_start+buf_len), a step smaller than buf_len, and a ring end that fits in AW bits. For that reason it only fires when those conditions hold. The bench walks its ring pointer by feeding each registered result back as the next base, so every ring access starts inside the buffer, and it uses steps of 3 against a length of 10. The upper-bit check for mirror mode covers only widths below AW. The bench still drives a width of 20 to exercise clamping, and it checks that case at the ports.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [2:0] {
      AM_DISP   = 3'd0,
      AM_INDEX  = 3'd1,
      AM_SCALED = 3'd2,
      AM_RING   = 3'd3,
      AM_MIRROR = 3'd4,
      AM_STRIDE = 3'd5,
      AM_RSV6   = 3'd6,
      AM_RSV7   = 3'd7
   } agu_mode_e;

   // Modes that walk a pointer and may write it back
   function automatic logic mode_walks(input agu_mode_e m);
      return (m == AM_RING) || (m == AM_MIRROR) || (m == AM_STRIDE);
   endfunction

   // Modes whose address is the pointer itself
   function automatic logic mode_is_ptr(input agu_mode_e m);
      return (m == AM_RING) || (m == AM_MIRROR) || (m == AM_STRIDE) ||
             (m == AM_RSV6) || (m == AM_RSV7);
   endfunction

endpackage

// File: rtl/agu_linear.sv
module agu_linear
   import agu_pkg::*;
#(
   parameter int AW  = 16,
   parameter int SHW = 2
) (
   input  agu_mode_e         mode,
   input  logic [AW-1:0]     base,
   input  logic [AW-1:0]     index,
   input  logic [AW-1:0]     offset,
   input  logic [SHW-1:0]    scale_sh,
   output logic [AW-1:0]     lin_addr
);

   logic [AW-1:0] addend;
   logic [AW-1:0] idx_scaled;

   assign idx_scaled = index << scale_sh;

   always_comb begin
      unique case (mode)
         AM_DISP:   addend = offset;
         AM_INDEX:  addend = index;
         AM_SCALED: addend = idx_scaled;
         default:   addend = '0;
      endcase
   end

   assign lin_addr = base + addend;

endmodule

// File: rtl/agu_mirror.sv
module agu_mirror #(
   parameter int AW = 16,
   parameter int NW = $clog2(AW + 1)
) (
   input  logic [AW-1:0] din,
   input  logic [NW-1:0] nbits,
   output logic [AW-1:0] dout
);

   localparam int IW = (AW > 1) ? $clog2(AW) : 1;
   localparam logic [NW-1:0] AW_N = NW'(AW);

   logic [NW-1:0] n_eff;

   assign n_eff = (nbits > AW_N) ? AW_N : nbits;

   // One mux per output bit: mirrored source below n_eff, own bit above
   for (genvar g = 0; g < AW; g++) begin : g_bit
      always_comb begin
         int src;
         logic [IW-1:0] sel;
         src = int'(n_eff) - 1 - g;
         sel = src[IW-1:0];
         if (g < int'(n_eff)) dout[g] = din[sel];
         else                 dout[g] = din[g];
      end
   end

endmodule

// File: rtl/agu_ring.sv
module agu_ring #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] step,
   input  logic [AW-1:0] start,
   input  logic [AW-1:0] len,
   output logic [AW-1:0] nxt
);

   localparam int EW = AW + 1;

   logic [EW-1:0] sum;
   logic [EW-1:0] limit;
   logic [EW-1:0] folded;

   assign sum    = {1'b0, ptr}   + {1'b0, step};
   assign limit  = {1'b0, start} + {1'b0, len};
   assign folded = sum - {1'b0, len};
   assign nxt    = (sum >= limit) ? folded[AW-1:0] : sum[AW-1:0];

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
   import agu_pkg::*;
#(
   parameter int AW  = 16,
   parameter int SHW = 2,
   parameter int NW  = $clog2(AW + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      mode,
   input  logic [AW-1:0]   base,
   input  logic [AW-1:0]   index,
   input  logic [AW-1:0]   offset,
   input  logic [SHW-1:0]  scale_sh,
   input  logic [AW-1:0]   buf_start,
   input  logic [AW-1:0]   buf_len,
   input  logic [AW-1:0]   step,
   input  logic [NW-1:0]   rev_bits,
   input  logic            upd_en,
   output logic [AW-1:0]   eff_addr,
   output logic [AW-1:0]   ptr_next,
   output logic            ptr_valid
);

   if (AW < 4 || AW > 64) begin : g_bad_aw
      $error("dsp_agu: AW must lie in 4..64");
   end
   if (SHW < 1 || (1 << SHW) > AW) begin : g_bad_shw
      $error("dsp_agu: SHW out of range for AW");
   end
   if (NW < $clog2(AW + 1)) begin : g_bad_nw
      $error("dsp_agu: NW too narrow to express AW");
   end

   agu_mode_e     m;
   logic [AW-1:0] lin_addr;
   logic [AW-1:0] mir_addr;
   logic [AW-1:0] ring_nxt;
   logic [AW-1:0] lin_nxt;
   logic [AW-1:0] walk_nxt;
   logic          load;

   assign m = agu_mode_e'(mode);

   agu_linear #(.AW(AW), .SHW(SHW)) u_lin (
      .mode     (m),
      .base     (base),
      .index    (index),
      .offset   (offset),
      .scale_sh (scale_sh),
      .lin_addr (lin_addr)
   );

   agu_mirror #(.AW(AW), .NW(NW)) u_mir (
      .din   (base),
      .nbits (rev_bits),
      .dout  (mir_addr)
   );

   agu_ring #(.AW(AW)) u_ring (
      .ptr   (base),
      .step  (step),
      .start (buf_start),
      .len   (buf_len),
      .nxt   (ring_nxt)
   );

   assign lin_nxt  = base + step;
   assign walk_nxt = (m == AM_RING) ? ring_nxt : lin_nxt;

   always_comb begin
      if (m == AM_MIRROR)      eff_addr = mir_addr;
      else if (mode_is_ptr(m)) eff_addr = base;
      else                     eff_addr = lin_addr;
   end

   assign load = upd_en && mode_walks(m);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_next  <= '0;
         ptr_valid <= 1'b0;
      end else begin
         ptr_valid <= load;
         if (load) ptr_next <= walk_nxt;
      end
   end

endmodule

// File: rtl/dsp_agu_chk.sv
module dsp_agu_chk #(
   parameter int AW = 16,
   parameter int NW = $clog2(AW + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    mode,
   input logic [AW-1:0] base,
   input logic [AW-1:0] index,
   input logic [AW-1:0] offset,
   input logic [AW-1:0] buf_start,
   input logic [AW-1:0] buf_len,
   input logic [AW-1:0] step,
   input logic [NW-1:0] rev_bits,
   input logic          upd_en,
   input logic [AW-1:0] eff_addr,
   input logic [AW-1:0] ptr_next,
   input logic          ptr_valid
);

   localparam logic [NW-1:0] AW_N = NW'(AW);

   logic [AW:0]   ring_end;
   logic          ring_ok;
   logic [AW-1:0] sum_lin;

   assign ring_end = {1'b0, buf_start} + {1'b0, buf_len};
   assign ring_ok  = (base >= buf_start) && ({1'b0, base} < ring_end) &&
                     (step < buf_len) && !ring_end[AW];
   assign sum_lin  = base + step;

   assert_disp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0) |-> (eff_addr == base + offset));

   assert_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1) |-> (eff_addr == base + index));

   assert_ring_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && mode == 3'd3 && ring_ok) |=>
         (ptr_valid && ptr_next >= $past(buf_start) &&
          {1'b0, ptr_next} < $past(ring_end)));

   assert_mirror_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 && rev_bits != '0 && rev_bits < AW_N) |->
         ((eff_addr >> rev_bits) == (base >> rev_bits)));

   assert_mirror_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 && rev_bits == '0) |-> (eff_addr == base));

   assert_stride_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && mode == 3'd5) |=> (ptr_valid && ptr_next == $past(sum_lin)));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> (!ptr_valid && $stable(ptr_next)));

   assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2:1] == 2'b11) |=> (!ptr_valid && $stable(ptr_next)));

endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW), .NW(NW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .base      (base),
   .index     (index),
   .offset    (offset),
   .buf_start (buf_start),
   .buf_len   (buf_len),
   .step      (step),
   .rev_bits  (rev_bits),
   .upd_en    (upd_en),
   .eff_addr  (eff_addr),
   .ptr_next  (ptr_next),
   .ptr_valid (ptr_valid)
);

// File: tb/sim_dsp_agu.sv
`timescale 1ns/1ps
module sim_dsp_agu;

   localparam int AW  = 16;
   localparam int SHW = 2;
   localparam int NW  = 5;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [2:0]      mode;
   logic [AW-1:0]   base, index, offset, buf_start, buf_len, step;
   logic [SHW-1:0]  scale_sh;
   logic [NW-1:0]   rev_bits;
   logic            upd_en;
   logic [AW-1:0]   eff_addr, ptr_next;
   logic            ptr_valid;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   dsp_agu #(.AW(AW), .SHW(SHW), .NW(NW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .base(base), .index(index),
      .offset(offset), .scale_sh(scale_sh), .buf_start(buf_start),
      .buf_len(buf_len), .step(step), .rev_bits(rev_bits), .upd_en(upd_en),
      .eff_addr(eff_addr), .ptr_next(ptr_next), .ptr_valid(ptr_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic t_reset();
      #1;
      chk("R1 ptr_next in reset", 32'(ptr_next), 32'h0);
      chk("R1 ptr_valid in reset", 32'(ptr_valid), 32'h0);
   endtask

   task automatic t_disp();
      upd_en = 1'b0; mode = 3'd0; base = 16'h1000; offset = 16'hFFFC; #1;
      chk("R2 negative displacement", 32'(eff_addr), 32'h0FFC);
      offset = 16'h0024; #1;
      chk("R2 positive displacement", 32'(eff_addr), 32'h1024);
      base = 16'h2000; #1;
      chk("R11 same-cycle base change", 32'(eff_addr), 32'h2024);
   endtask

   task automatic t_index();
      mode = 3'd1; base = 16'h1234; index = 16'h0100; #1;
      chk("R3 indexed", 32'(eff_addr), 32'h1334);
      base = 16'hFFF0; index = 16'h0020; #1;
      chk("R3 indexed wrap", 32'(eff_addr), 32'h0010);
   endtask

   task automatic t_scaled();
      mode = 3'd2; base = 16'h2000; index = 16'h0005; scale_sh = 2'd3; #1;
      chk("R4 row size 8", 32'(eff_addr), 32'h2028);
      scale_sh = 2'd0; #1;
      chk("R4 scale 1", 32'(eff_addr), 32'h2005);
      scale_sh = 2'd2; #1;
      chk("R4 scale 4", 32'(eff_addr), 32'h2014);
   endtask

   task automatic t_ring();
      logic [AW-1:0] exp_seq [5] = '{16'h0103, 16'h0106, 16'h0109, 16'h0102, 16'h0105};
      logic [AW-1:0] cur;
      mode = 3'd3; buf_start = 16'h0100; buf_len = 16'd10; step = 16'd3;
      upd_en = 1'b1; cur = 16'h0100;
      for (int i = 0; i < 5; i++) begin
         base = cur; #1;
         chk("R5 ring address is pointer", 32'(eff_addr), 32'(cur));
         tick();
         chk("R5 ring next pointer", 32'(ptr_next), 32'(exp_seq[i]));
         chk("R9 valid after ring update", 32'(ptr_valid), 32'h1);
         cur = exp_seq[i];
      end
      base = 16'h0107; tick();
      chk("R5 ring exact end wraps to start", 32'(ptr_next), 32'h0100);
      upd_en = 1'b0;
   endtask

   task automatic t_mirror();
      mode = 3'd4; base = 16'hABCD;
      rev_bits = 5'd4;  #1; chk("R6 mirror 4 bits", 32'(eff_addr), 32'hABCB);
      rev_bits = 5'd8;  #1; chk("R6 mirror 8 bits", 32'(eff_addr), 32'hABB3);
      rev_bits = 5'd16; #1; chk("R6 mirror 16 bits", 32'(eff_addr), 32'hB3D5);
      rev_bits = 5'd20; #1; chk("R6 mirror width clamped", 32'(eff_addr), 32'hB3D5);
      rev_bits = 5'd0;  #1; chk("R7 width 0 passes through", 32'(eff_addr), 32'hABCD);
      base = 16'h0006; rev_bits = 5'd3; #1;
      chk("R6 mirror 3 bits", 32'(eff_addr), 32'h0003);
      base = 16'hABCD; step = 16'd1; upd_en = 1'b1; tick();
      chk("R6 mirror pointer advance", 32'(ptr_next), 32'hABCE);
      upd_en = 1'b0;
   endtask

   task automatic t_stride();
      mode = 3'd5; base = 16'hFFFE; step = 16'd5; upd_en = 1'b1; #1;
      chk("R8 stride address is pointer", 32'(eff_addr), 32'hFFFE);
      tick();
      chk("R8 stride wraps modulo", 32'(ptr_next), 32'h0003);
      chk("R9 valid after stride update", 32'(ptr_valid), 32'h1);
   endtask

   task automatic t_hold();
      mode = 3'd5; base = 16'h5555; upd_en = 1'b0; tick();
      chk("R9 pointer held without enable", 32'(ptr_next), 32'h0003);
      chk("R9 valid low without enable", 32'(ptr_valid), 32'h0);
   endtask

   task automatic t_reserved();
      mode = 3'd6; base = 16'h7777; upd_en = 1'b1; #1;
      chk("R10 reserved address is base", 32'(eff_addr), 32'h7777);
      tick();
      chk("R10 reserved no pointer load", 32'(ptr_next), 32'h0003);
      chk("R10 reserved no valid", 32'(ptr_valid), 32'h0);
      mode = 3'd7; tick();
      chk("R10 mode 7 no valid", 32'(ptr_valid), 32'h0);
      upd_en = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; mode = '0; base = '0; index = '0; offset = '0;
      scale_sh = '0; buf_start = '0; buf_len = '0; step = '0;
      rev_bits = '0; upd_en = 1'b0;
      repeat (2) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_disp();
      t_index();
      t_scaled();
      t_ring();
      t_mirror();
      t_stride();
      t_hold();
      t_reserved();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

endmodule